// File: doc/BRIEF.md
# I2C Pointer-Register Target

This block is an I2C target that presents a small bank of 16-bit registers behind an 8-bit pointer. It watches the open-drain clock and data lines through synchronizers and pulls the data line low through a single drive-enable output. Every bus event is decoded from the sampled lines on the system clock. The block does not stretch the clock.

A controller first runs a write transaction to the fixed 7-bit address 48h and sends one pointer byte. The target acknowledges both bytes and keeps the pointer. The pointer survives the STOP. A later read transaction to the same address returns the 16-bit word that the pointer selects, high byte first. Word 0 is the conversion-result word in two's-complement form. The target copies the selected word into a shift register when it acknowledges the read address, so both bytes come from the same value.

The register words arrive on a flat parallel input. A debug output shows the stored pointer.

Top module: `i2c_ptr_target`

## Requirements
- R1: While reset is active and right after it is released, `sda_oe_o` is 0 and `ptr_o` is 00h. A read issued before any pointer write returns word 0.
- R2: An address byte whose upper seven bits equal 48h is acknowledged. The target holds SDA low across the high phase of the ninth clock. The drive begins only in an acknowledge phase or in a data bit.
- R3: After an address byte that does not match, the target leaves SDA released until the next START. Later bytes are not acknowledged, and a read of that address returns FFh.
- R4: In a write transaction (address LSB = 0), the byte after the address is stored as the pointer and acknowledged, and `ptr_o` then shows it. The pointer changes at no other time.
- R5: The pointer is kept across a STOP. Every later read transaction returns the word it selects, until a new pointer is written.
- R6: In a read transaction (address LSB = 1), the target sends the upper byte of the selected word and then the lower byte, each MSB first. It changes SDA only while SCL is low.
- R7: Pointer 00h selects word 0 (bits 15:0 of `reg_words_i`). That word is sent unchanged as a two's-complement code, including 7FFFh and 8000h.
- R8: Pointer n selects bits n*16+15 down to n*16 of `reg_words_i`. A pointer of NUM_REGS or more reads as 0000h.
- R9: The word sent in a read is the value that `reg_words_i` held when the read address was acknowledged. Later changes to `reg_words_i` do not alter the bytes.
- R10: If the controller NACKs the first data byte, the target releases SDA, so the next byte reads FFh.
- R11: After the second data byte the target releases SDA even if the controller acknowledges it, so a third byte reads FFh.
- R12: A STOP or a repeated START in the middle of the pointer byte abandons that byte and leaves the stored pointer unchanged. A read after a repeated START still returns the old pointer's word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| reg_words_i | input | NUM_REGS*16 | Register words, word n in bits n*16+15:n*16 |
| sda_oe_o | output | 1 | Drive enable that pulls the data line low when 1 |
| ptr_o | output | 8 | Stored register pointer (debug) |

## Verification
Directed transactions cover the following cases:
- a read before any write, to check the reset pointer;
- pointer 00h with the full-scale codes 7FFFh and 8000h;
- an out-of-range pointer;
- a foreign address, in both write and read form.

Early endings are tried separately:
- a NACK on the first byte;
- an acknowledged third byte;
- a STOP or repeated START inside the pointer byte.

Each of these is told apart by its own byte values or acknowledge bits.

A read that changes the register words right after the address acknowledge tells a snapshot apart from a live mux. Random register contents and random pointers, some out of range, written and then read in separate transactions, tell correct word selection and byte order apart from swapped bytes or a pointer lost at STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR     = 3'd1,
    ST_ADDR_ACK = 3'd2,
    ST_PTR      = 3'd3,
    ST_PTR_ACK  = 3'd4,
    ST_TX       = 3'd5,
    ST_TX_ACK   = 3'd6,
    ST_WAIT     = 3'd7
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes one open-drain bus line and flags its edges.
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/i2c_reg_select.sv
// Picks the word addressed by the pointer; unused pointers read as zero.
module i2c_reg_select #(
  parameter int NUM_REGS = 4,
  parameter int WORD_W   = 16,
  parameter int PTR_W    = 8
) (
  input  logic [PTR_W-1:0]           ptr_i,
  input  logic [NUM_REGS*WORD_W-1:0] regs_i,
  output logic [WORD_W-1:0]          word_o
);
  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr_i == PTR_W'(i)) word_o = regs_i[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Bus sequencer: address match, pointer capture, read shifting.
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h48,
  parameter int         WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [WORD_W-1:0] sel_word_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ptr_o,
  output tgt_state_e        state_o
);
  localparam int NBYTES  = WORD_W / BYTE_W;
  localparam int BYTE_IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  tgt_state_e          state_q, state_d;
  logic [3:0]          bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0]   shin_q, shin_d;
  logic [WORD_W-1:0]   shout_q, shout_d;
  logic [BYTE_IW-1:0]  byte_q, byte_d;
  logic                ackph_q, ackph_d;
  logic                rw_q, rw_d;
  logic                oe_q, oe_d;
  logic [BYTE_W-1:0]   ptr_q, ptr_d;
  logic [BYTE_W-1:0]   shin_next;

  assign shin_next = {shin_q[BYTE_W-2:0], sda_lvl_i};

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shin_d   = shin_q;
    shout_d  = shout_q;
    byte_d   = byte_q;
    ackph_d  = ackph_q;
    rw_d     = rw_q;
    oe_d     = oe_q;
    ptr_d    = ptr_q;
    if (stop_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      ackph_d = 1'b0;
    end else if (start_i) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      oe_d     = 1'b0;
      ackph_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            shin_d   = shin_next;
            bitcnt_d = bitcnt_q + 4'd1;
            if (bitcnt_q == 4'd7) begin
              if (shin_q[6:0] == TARGET_ADDR) begin
                state_d = ST_ADDR_ACK;
                rw_d    = sda_lvl_i;
              end else begin
                state_d = ST_WAIT;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            if (!ackph_q) begin
              oe_d    = 1'b1;
              ackph_d = 1'b1;
              if (rw_q) shout_d = sel_word_i;
            end else begin
              ackph_d  = 1'b0;
              bitcnt_d = '0;
              if (rw_q) begin
                state_d = ST_TX;
                byte_d  = '0;
                oe_d    = ~shout_q[WORD_W-1];
              end else begin
                state_d = ST_PTR;
                oe_d    = 1'b0;
              end
            end
          end
        end
        ST_PTR: begin
          if (scl_rise_i) begin
            shin_d   = shin_next;
            bitcnt_d = bitcnt_q + 4'd1;
            if (bitcnt_q == 4'd7) begin
              ptr_d   = shin_next;
              state_d = ST_PTR_ACK;
            end
          end
        end
        ST_PTR_ACK: begin
          if (scl_fall_i) begin
            if (!ackph_q) begin
              oe_d    = 1'b1;
              ackph_d = 1'b1;
            end else begin
              oe_d    = 1'b0;
              ackph_d = 1'b0;
              state_d = ST_WAIT;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (bitcnt_q == 4'd8) begin
              oe_d     = 1'b0;
              bitcnt_d = '0;
              state_d  = ST_TX_ACK;
            end else begin
              shout_d = shout_q << 1;
              oe_d    = ~shout_q[WORD_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            if (!sda_lvl_i && (byte_q != BYTE_IW'(NBYTES-1))) ackph_d = 1'b1;
            else state_d = ST_WAIT;
          end else if (scl_fall_i && ackph_q) begin
            ackph_d = 1'b0;
            byte_d  = byte_q + 1'b1;
            state_d = ST_TX;
            shout_d = shout_q << 1;
            oe_d    = ~shout_q[WORD_W-2];
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shin_q   <= '0;
      shout_q  <= '0;
      byte_q   <= '0;
      ackph_q  <= 1'b0;
      rw_q     <= 1'b0;
      oe_q     <= 1'b0;
      ptr_q    <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shin_q   <= shin_d;
      shout_q  <= shout_d;
      byte_q   <= byte_d;
      ackph_q  <= ackph_d;
      rw_q     <= rw_d;
      oe_q     <= oe_d;
      ptr_q    <= ptr_d;
    end
  end

  assign sda_oe_o = oe_q;
  assign ptr_o    = ptr_q;
  assign state_o  = state_q;
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h48,
  parameter int         NUM_REGS    = 4,
  parameter int         WORD_W      = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [NUM_REGS*WORD_W-1:0] reg_words_i,
  output logic                       sda_oe_o,
  output logic [BYTE_W-1:0]          ptr_o
);
  localparam int NLINES = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NLINES-1:0] line_in, line_lvl, line_rise, line_fall;
  logic              start_evt, stop_evt;
  logic [WORD_W-1:0] sel_word;
  tgt_state_e        fsm_state;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .line_i (line_in[g]),
      .level_o(line_lvl[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  // Index 0 is SCL, index 1 is SDA. SCL must have been high for two samples.
  assign start_evt = line_fall[1] & line_lvl[0] & ~line_rise[0];
  assign stop_evt  = line_rise[1] & line_lvl[0] & ~line_rise[0];

  i2c_reg_select #(
    .NUM_REGS(NUM_REGS),
    .WORD_W  (WORD_W),
    .PTR_W   (BYTE_W)
  ) u_sel (
    .ptr_i (ptr_o),
    .regs_i(reg_words_i),
    .word_o(sel_word)
  );

  i2c_tgt_fsm #(
    .TARGET_ADDR(TARGET_ADDR),
    .WORD_W     (WORD_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_rise_i(line_rise[0]),
    .scl_fall_i(line_fall[0]),
    .sda_lvl_i (line_lvl[1]),
    .start_i   (start_evt),
    .stop_i    (stop_evt),
    .sel_word_i(sel_word),
    .sda_oe_o  (sda_oe_o),
    .ptr_o     (ptr_o),
    .state_o   (fsm_state)
  );
endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk
  import i2c_tgt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [BYTE_W-1:0] ptr_o,
  input tgt_state_e        state_i
);
  AST_DRIVE_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i); // R6

  AST_PTR_ONLY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr_o) |-> ($past(state_i) == ST_PTR)); // R4

  AST_QUIET_STATES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_IDLE || state_i == ST_ADDR || state_i == ST_PTR ||
     state_i == ST_WAIT || state_i == ST_TX_ACK) |-> !sda_oe_o); // R3

  AST_DRIVE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |->
      (state_i == ST_ADDR_ACK || state_i == ST_PTR_ACK || state_i == ST_TX)); // R2
endmodule

bind i2c_ptr_target i2c_ptr_target_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .sda_oe_o(sda_oe_o),
  .ptr_o   (ptr_o),
  .state_i (fsm_state)
);

// File: tb/i2c_ptr_target_tb_top.sv
`timescale 1ns/1ps
module i2c_ptr_target_tb_top;
  localparam int NREG = 4;
  localparam int WW   = 16;
  localparam int QTR  = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             scl, sda_drv;
  logic [NREG*WW-1:0] regs;
  logic             sda_oe;
  logic [7:0]       ptr;
  wire              sda_line = sda_drv & ~sda_oe;
  int               checks = 0;
  int               fails  = 0;
  bit               done   = 0;

  always #10 clk = ~clk;

  i2c_ptr_target dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .reg_words_i(regs),
    .sda_oe_o   (sda_oe),
    .ptr_o      (ptr)
  );

  function automatic logic [15:0] exp_word(logic [NREG*WW-1:0] r, logic [7:0] p);
    if (p < NREG) return r[p*WW +: WW];
    return 16'h0000;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; q(); scl = 1'b1; q(); sda_drv = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; q(); scl = 1'b1; q(); sda_drv = 1'b1; q();
  endtask

  task automatic bit_cycle(input logic b, output logic r);
    sda_drv = b; q(); scl = 1'b1; q(); r = sda_line; q(); scl = 1'b0; q();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_cycle(d[i], r);
    bit_cycle(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, r);
      d[i] = r;
    end
    bit_cycle(~give_ack, r);
  endtask

  task automatic write_ptr(input logic [7:0] p, output logic a1, output logic a2);
    bus_start();
    write_byte(8'h90, a1);
    write_byte(p, a2);
    bus_stop();
  endtask

  task automatic read_word(input bit flip_mid, output logic [7:0] hi,
                           output logic [7:0] lo, output logic aa);
    bus_start();
    write_byte(8'h91, aa);
    if (flip_mid) regs = ~regs;
    read_byte(1'b1, hi);
    read_byte(1'b0, lo);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a1, a2, aa, r;
    logic [7:0] hi, lo, b3;
    logic [15:0] expw;
    logic [7:0] p;
    rst_n = 1'b0; scl = 1'b1; sda_drv = 1'b1;
    regs = {16'h4444, 16'h1234, 16'h0001, 16'h8000};
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 0);
    chk("R1 ptr in reset", ptr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", sda_oe, 0);

    // Read before any write: pointer 0, negative full scale
    read_word(0, hi, lo, aa);
    chk("R2 read address ack", aa, 1);
    chk("R1 R7 word0 8000h", {hi, lo}, 16'h8000);

    write_ptr(8'h00, a1, a2);
    chk("R2 write address ack", a1, 1);
    chk("R4 pointer byte ack", a2, 1);
    chk("R4 ptr_o 00h", ptr, 8'h00);
    regs[15:0] = 16'h7FFF;
    read_word(0, hi, lo, aa);
    chk("R7 word0 7FFFh", {hi, lo}, 16'h7FFF);

    // Pointer 2 kept across STOPs, byte order
    write_ptr(8'h02, a1, a2);
    chk("R4 ptr_o 02h", ptr, 8'h02);
    read_word(0, hi, lo, aa);
    chk("R6 upper byte first", hi, 8'h12);
    chk("R6 lower byte second", lo, 8'h34);
    read_word(0, hi, lo, aa);
    chk("R5 second read same ptr", {hi, lo}, 16'h1234);

    // Out-of-range pointer
    write_ptr(8'hF0, a1, a2);
    chk("R8 ptr_o F0h", ptr, 8'hF0);
    read_word(0, hi, lo, aa);
    chk("R8 out of range zero", {hi, lo}, 16'h0000);
    write_ptr(8'h03, a1, a2);
    read_word(0, hi, lo, aa);
    chk("R8 last word", {hi, lo}, 16'h4444);

    // Foreign address
    bus_start();
    write_byte(8'h94, a1);
    write_byte(8'h01, a2);
    bus_stop();
    chk("R3 foreign addr nack", a1, 0);
    chk("R3 foreign data nack", a2, 0);
    chk("R3 ptr unchanged", ptr, 8'h03);
    bus_start();
    write_byte(8'h93, a1);
    read_byte(1'b0, hi);
    bus_stop();
    chk("R3 foreign read nack", a1, 0);
    chk("R3 foreign read FFh", hi, 8'hFF);

    // Snapshot at read address ack
    write_ptr(8'h01, a1, a2);
    regs[31:16] = 16'hA55A;
    read_word(1, hi, lo, aa);
    chk("R9 snapshot word", {hi, lo}, 16'hA55A);
    regs = {16'h4444, 16'h1234, 16'hC3E1, 16'h8000};

    // NACK first byte
    bus_start();
    write_byte(8'h91, aa);
    read_byte(1'b0, hi);
    read_byte(1'b0, lo);
    bus_stop();
    chk("R10 first byte", hi, 8'hC3);
    chk("R10 released after nack", lo, 8'hFF);

    // Third byte after two acked bytes
    bus_start();
    write_byte(8'h91, aa);
    read_byte(1'b1, hi);
    read_byte(1'b1, lo);
    read_byte(1'b0, b3);
    bus_stop();
    chk("R11 two bytes", {hi, lo}, 16'hC3E1);
    chk("R11 third byte FFh", b3, 8'hFF);

    // STOP in the middle of the pointer byte
    bus_start();
    write_byte(8'h90, a1);
    bit_cycle(1'b0, r); bit_cycle(1'b0, r); bit_cycle(1'b1, r); bit_cycle(1'b1, r);
    bus_stop();
    chk("R12 stop mid byte ptr kept", ptr, 8'h01);
    // Repeated START in the middle of the pointer byte
    bus_start();
    write_byte(8'h90, a1);
    bit_cycle(1'b0, r); bit_cycle(1'b0, r); bit_cycle(1'b0, r);
    bus_start();
    write_byte(8'h91, aa);
    read_byte(1'b1, hi);
    read_byte(1'b0, lo);
    bus_stop();
    chk("R12 restart ptr kept", ptr, 8'h01);
    chk("R12 restart read ack", aa, 1);
    chk("R12 restart read word", {hi, lo}, 16'hC3E1);

    // Random pointers and contents
    void'($urandom(32'h1F2E3D4C));
    for (int it = 0; it < 24; it++) begin
      for (int w = 0; w < NREG; w++) regs[w*WW +: WW] = 16'($urandom);
      if (it % 4 == 3) p = 8'($urandom);
      else p = 8'($urandom_range(0, NREG + 1));
      write_ptr(p, a1, a2);
      chk("R4 random ptr_o", ptr, p);
      expw = exp_word(regs, p);
      read_word(0, hi, lo, aa);
      chk("R5 R6 random word", {hi, lo}, expw);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule